// File: doc/BRIEF.md
# Six-Channel Interval Timer

This block is a bank of independent interval timers behind a small synchronous register port. Each channel has a 28-bit up-counter fed through its own clock divider. When the counter reaches a programmed target, the channel latches a pending flag. Then, depending on its mode, the channel either wraps to zero and keeps running, or parks at the target and switches itself off. The pending flag, gated by a per-channel enable, drives one interrupt line per channel.

Software programs a channel in a fixed order. It writes the target, optionally zeroes the counter, enables the interrupt, and then writes the control word with the run bit, the mode bit and a divisor. To acknowledge an event it writes a one to the pending bit. To stop a channel at any time it writes the whole control word as zero.

Top module: `multi_timer`

## Requirements
- R1: After reset every register of every channel reads zero and all interrupt lines are low.
- R2: Channel c occupies byte offsets 16*c to 16*c+15, with word 0 the target, word 1 the count, word 2 the control and word 3 the interrupt register. Read data appears on `rdata` one cycle after a cycle with `rd_en` high. Unused bits read zero. An address past the last channel reads zero, and writing it changes nothing.
- R3: In the control word, bit 28 runs the channel, bit 24 selects repeat (1) or once (0), and bits 15:0 hold the divisor. While bit 28 is zero the count does not move, so writing the control word as zero stops the channel.
- R4: A running channel advances its count by one every D clocks, where D is the divisor field. A field of 0 or 1 acts as 2. The first advance comes D clocks after the control write.
- R5: In once mode, an advance that reaches or passes the target sets pending, leaves the count equal to the target and clears the run bit.
- R6: In repeat mode, an advance that reaches or passes the target sets pending, puts the count back to zero and keeps running.
- R7: Bit 16 of the interrupt register is the pending flag. Writing 1 there clears it and writing 0 leaves it alone. If an event sets the flag in the same cycle as a clearing write, the flag stays set.
- R8: Bit 20 of the interrupt register is the interrupt enable. Each `irq` line is high exactly while that channel's pending flag and enable are both set.
- R9: Target and count hold 28 bits. Writes keep the low 28 bits, so the largest period is 0x0FFFFFFF.
- R10: A write to a channel's count or control register restarts its divider phase. That channel does not advance in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | NUM_CH (6) | Per-channel interrupt requests |

## Verification
The bound checker watches, on every cycle and for every channel, five things:
- a pending flag only falls right after a one-to-clear write to that channel's interrupt register;
- a stopped channel's count stays put unless it is written;
- a self-clearing run bit leaves pending set and the count at the target;
- a wrap to zero without a write comes with pending set;
- no interrupt line is high without both pending and enable.

The exact divider spacing, the mode outcomes, field truncation, out-of-range addresses and the set-beats-clear race are shown only by the bench. Its cycle-accurate reference model is compared against every interrupt line each cycle and against every read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W   = 32;
  localparam int RUN_BIT  = 28;
  localparam int MODE_BIT = 24;
  localparam int PEND_BIT = 16;
  localparam int IEN_BIT  = 20;

  typedef enum logic [1:0] {
    SLOT_TGT  = 2'd0,
    SLOT_CNT  = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_IRQ  = 2'd3
  } slot_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] ph_q, ph_d, div_eff;

  always_comb begin
    div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
    tick    = run && !restart && (ph_q == div_eff - DIV_W'(1));
    if (!run || restart || tick) ph_d = '0;
    else                         ph_d = ph_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 28,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tgt,
  input  logic              wr_cnt,
  input  logic              wr_ctrl,
  input  logic              wr_int,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  tgt_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              run_o,
  output logic              rep_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              pend_o,
  output logic              ien_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] tgt_q, tgt_d, cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             run_q, run_d, rep_q, rep_d, pend_q, pend_d, ien_q, ien_d;
  logic             tick, hit;
  logic [CNT_W:0]   cnt_inc;

  tmr_prescaler #(.DIV_W(DIV_W)) i_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (wr_cnt | wr_ctrl),
    .div     (div_q),
    .tick    (tick)
  );

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    hit     = tick && (cnt_inc >= {1'b0, tgt_q});

    tgt_d  = tgt_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    rep_d  = rep_q;
    div_d  = div_q;
    pend_d = pend_q;
    ien_d  = ien_q;

    if (tick) begin
      if (hit) begin
        pend_d = 1'b1;
        if (rep_q) cnt_d = '0;
        else begin
          cnt_d = tgt_q;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end

    if (wr_tgt) tgt_d = wdata[CNT_W-1:0];
    if (wr_cnt) cnt_d = wdata[CNT_W-1:0];
    if (wr_ctrl) begin
      run_d = wdata[RUN_BIT];
      rep_d = wdata[MODE_BIT];
      div_d = wdata[DIV_W-1:0];
    end
    if (wr_int) begin
      ien_d = wdata[IEN_BIT];
      if (wdata[PEND_BIT] && !hit) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      rep_q  <= 1'b0;
      div_q  <= '0;
      pend_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      rep_q  <= rep_d;
      div_q  <= div_d;
      pend_q <= pend_d;
      ien_q  <= ien_d;
    end
  end

  assign tgt_o  = tgt_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign rep_o  = rep_q;
  assign div_o  = div_q;
  assign pend_o = pend_q;
  assign ien_o  = ien_q;
  assign irq_o  = pend_q & ien_q;
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 28,
  parameter int DIV_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] tgt_v,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input  logic [NUM_CH-1:0]            run_v,
  input  logic [NUM_CH-1:0]            rep_v,
  input  logic [NUM_CH-1:0][DIV_W-1:0] div_v,
  input  logic [NUM_CH-1:0]            pend_v,
  input  logic [NUM_CH-1:0]            ien_v,
  output logic [NUM_CH-1:0]            wr_tgt,
  output logic [NUM_CH-1:0]            wr_cnt,
  output logic [NUM_CH-1:0]            wr_ctrl,
  output logic [NUM_CH-1:0]            wr_int,
  output logic [WORD_W-1:0]            rdata
);
  localparam int CHW = ADDR_W - 4;

  logic [CHW-1:0]    ch_idx;
  slot_e             slot;
  logic [WORD_W-1:0] rd_word, rdata_q;

  assign ch_idx = addr[ADDR_W-1:4];
  assign slot   = slot_e'(addr[3:2]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit_ch;
    assign hit_ch     = wr_en && (ch_idx == CHW'(g));
    assign wr_tgt[g]  = hit_ch && (slot == SLOT_TGT);
    assign wr_cnt[g]  = hit_ch && (slot == SLOT_CNT);
    assign wr_ctrl[g] = hit_ch && (slot == SLOT_CTRL);
    assign wr_int[g]  = hit_ch && (slot == SLOT_IRQ);
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CHW'(i)) begin
        case (slot)
          SLOT_TGT:  rd_word[CNT_W-1:0] = tgt_v[i];
          SLOT_CNT:  rd_word[CNT_W-1:0] = cnt_v[i];
          SLOT_CTRL: begin
            rd_word[RUN_BIT]    = run_v[i];
            rd_word[MODE_BIT]   = rep_v[i];
            rd_word[DIV_W-1:0]  = div_v[i];
          end
          default: begin
            rd_word[PEND_BIT] = pend_v[i];
            rd_word[IEN_BIT]  = ien_v[i];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/multi_timer.sv
module multi_timer #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 28,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0][CNT_W-1:0] tgt_v, cnt_v;
  logic [NUM_CH-1:0][DIV_W-1:0] div_v;
  logic [NUM_CH-1:0]            run_v, rep_v, pend_v, ien_v;
  logic [NUM_CH-1:0]            wr_tgt, wr_cnt, wr_ctrl, wr_int;

  tmr_regbus #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) i_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .tgt_v(tgt_v), .cnt_v(cnt_v), .run_v(run_v), .rep_v(rep_v),
    .div_v(div_v), .pend_v(pend_v), .ien_v(ien_v),
    .wr_tgt(wr_tgt), .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl), .wr_int(wr_int),
    .rdata(rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_tgt(wr_tgt[g]), .wr_cnt(wr_cnt[g]), .wr_ctrl(wr_ctrl[g]),
      .wr_int(wr_int[g]), .wdata(wdata),
      .tgt_o(tgt_v[g]), .cnt_o(cnt_v[g]), .run_o(run_v[g]), .rep_o(rep_v[g]),
      .div_o(div_v[g]), .pend_o(pend_v[g]), .ien_o(ien_v[g]), .irq_o(irq[g])
    );
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 28
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            addr,
  input logic [31:0]                  wdata,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            pend_v,
  input logic [NUM_CH-1:0]            ien_v,
  input logic [NUM_CH-1:0]            run_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] tgt_v
);
  localparam int CHW = ADDR_W - 4;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_v[g]) |-> ($past(wr_en) && $past(addr[ADDR_W-1:4]) == CHW'(g)
                            && $past(addr[3:2]) == 2'd3 && $past(wdata[16])));
    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_v[g]) && !$past(wr_en)) |-> $stable(cnt_v[g]));
    // R5
    once_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_v[g]) && !$past(wr_en)) |-> (pend_v[g] && cnt_v[g] == tgt_v[g]));
    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_v[g]) && !$past(wr_en) && $past(cnt_v[g]) != '0 && cnt_v[g] == '0)
        |-> pend_v[g]);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (pend_v[g] && ien_v[g]));
  end
endmodule

bind multi_timer tmr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .pend_v(pend_v), .ien_v(ien_v), .run_v(run_v),
  .cnt_v(cnt_v), .tgt_v(tgt_v)
);

// File: tb/test_multi_timer.sv
`timescale 1ns/1ps
module test_multi_timer;
  localparam int NCH  = 6;
  localparam int MASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_tgt [NCH];
  int m_cnt [NCH];
  int m_div [NCH];
  int m_ph  [NCH];
  bit m_run [NCH];
  bit m_rep [NCH];
  bit m_pend[NCH];
  bit m_ien [NCH];
  logic [31:0] exp_rd;

  always #10 clk = ~clk;

  multi_timer i_multi_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] m_read(int ch, int slot);
    logic [31:0] v = '0;
    if (ch < NCH) begin
      case (slot)
        0: v = m_tgt[ch];
        1: v = m_cnt[ch];
        2: begin v[28] = m_run[ch]; v[24] = m_rep[ch]; v[15:0] = m_div[ch][15:0]; end
        default: begin v[16] = m_pend[ch]; v[20] = m_ien[ch]; end
      endcase
    end
    return v;
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk) begin
    int ch, slot;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_tgt[c] = 0; m_cnt[c] = 0; m_div[c] = 0; m_ph[c] = 0;
        m_run[c] = 0; m_rep[c] = 0; m_pend[c] = 0; m_ien[c] = 0;
      end
    end else begin
      ch = int'(addr) / 16;
      slot = (int'(addr) / 4) % 4;
      if (rd_en) exp_rd = m_read(ch, slot);
      for (int c = 0; c < NCH; c++) begin
        bit sel, restart, tick, hit;
        int dv;
        sel = wr_en && ch == c;
        restart = sel && (slot == 1 || slot == 2);
        dv = (m_div[c] < 2) ? 2 : m_div[c];
        tick = m_run[c] && !restart && (m_ph[c] == dv - 1);
        if (!m_run[c] || restart || tick) m_ph[c] = 0; else m_ph[c] = m_ph[c] + 1;
        hit = tick && (m_cnt[c] + 1 >= m_tgt[c]);
        if (tick) begin
          if (hit) begin
            m_pend[c] = 1;
            if (m_rep[c]) m_cnt[c] = 0;
            else begin m_cnt[c] = m_tgt[c]; m_run[c] = 0; end
          end else m_cnt[c] = m_cnt[c] + 1;
        end
        if (sel) begin
          case (slot)
            0: m_tgt[c] = int'(wdata) & MASK;
            1: m_cnt[c] = int'(wdata) & MASK;
            2: begin m_run[c] = wdata[28]; m_rep[c] = wdata[24]; m_div[c] = int'(wdata[15:0]); end
            default: begin
              m_ien[c] = wdata[20];
              if (wdata[16] && !hit) m_pend[c] = 0;
            end
          endcase
        end
      end
    end
  end

  // R8: every interrupt line against the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        total++;
        if (irq[c] !== (m_pend[c] & m_ien[c])) begin
          bad++;
          $display("FAIL R8 irq[%0d] actual=%0b expected=%0b", c, irq[c], m_pend[c] & m_ien[c]);
        end
      end
    end
  end

  function automatic logic [7:0] ra(int ch, int slot);
    return 8'(ch * 16 + slot * 4);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, string req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    total++;
    if (rdata !== exp_rd) begin
      bad++;
      $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, rdata, exp_rd);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd_chk(ra(0, 2), "R1");
    rd_chk(ra(3, 3), "R1");
    rd_chk(ra(5, 1), "R1");

    // R9 truncation to 28 bits
    wr(ra(5, 0), 32'hFFFF_FFFF);
    rd_chk(ra(5, 0), "R9");
    wr(ra(5, 1), 32'hF123_4567);
    rd_chk(ra(5, 1), "R9");

    // R2 out-of-range channel and unused bits
    wr(ra(6, 0), 32'h5);
    rd_chk(ra(6, 0), "R2");
    rd_chk(ra(0, 0), "R2");
    wr(ra(4, 2), 32'hFFFF_FFFF);
    rd_chk(ra(4, 2), "R2");
    wr(ra(4, 3), 32'hFFFF_FFFF);
    rd_chk(ra(4, 3), "R2");
    wr(ra(4, 2), 32'h0);
    rd_chk(ra(4, 2), "R3");

    // R4 R6 repeat mode, divisor 2
    wr(ra(0, 0), 32'd5);
    wr(ra(0, 3), 32'h0010_0000);
    wr(ra(0, 2), 32'h1100_0002);
    for (int k = 0; k < 8; k++) begin
      rd_chk(ra(0, 1), "R4");
      idle(2);
    end
    rd_chk(ra(0, 1), "R6");
    rd_chk(ra(0, 3), "R8");
    // R7 clear, then write zero leaves pending
    wr(ra(0, 3), 32'h0011_0000);
    rd_chk(ra(0, 3), "R7");
    idle(12);
    wr(ra(0, 3), 32'h0010_0000);
    rd_chk(ra(0, 3), "R7");

    // R3 stop by zero control word, count holds
    wr(ra(0, 2), 32'h0);
    rd_chk(ra(0, 1), "R3");
    idle(9);
    rd_chk(ra(0, 1), "R3");

    // R5 once mode, divisor field 0 acts as 2
    wr(ra(1, 0), 32'd3);
    wr(ra(1, 3), 32'h0010_0000);
    wr(ra(1, 2), 32'h1000_0000);
    rd_chk(ra(1, 1), "R4");
    idle(2);
    rd_chk(ra(1, 1), "R4");
    idle(12);
    rd_chk(ra(1, 2), "R5");
    rd_chk(ra(1, 1), "R5");
    rd_chk(ra(1, 3), "R5");

    // R4 divisor 5, R10 count restart, R8 enable off
    wr(ra(2, 0), 32'd4);
    wr(ra(2, 2), 32'h1100_0005);
    idle(7);
    rd_chk(ra(2, 1), "R4");
    wr(ra(2, 1), 32'h0);
    rd_chk(ra(2, 1), "R10");
    idle(3);
    rd_chk(ra(2, 1), "R10");
    idle(25);
    rd_chk(ra(2, 3), "R8");
    for (int k = 0; k < 5; k++) begin
      wr(ra(2, 2), 32'h1100_0005);
      idle(2);
    end
    rd_chk(ra(2, 1), "R10");

    // R7 set wins over clear: target 1 fires every other cycle
    wr(ra(3, 0), 32'd1);
    wr(ra(3, 3), 32'h0010_0000);
    wr(ra(3, 2), 32'h1100_0001);
    for (int k = 0; k < 6; k++) begin
      wr(ra(3, 3), 32'h0011_0000);
      rd_chk(ra(3, 3), "R7");
    end
    wr(ra(3, 2), 32'h0);
    wr(ra(3, 3), 32'h0001_0000);
    rd_chk(ra(3, 3), "R7");

    // R9 large period runs from near the top of the range
    wr(ra(5, 1), 32'h0FFF_FFF0);
    wr(ra(5, 2), 32'h1000_0002);
    idle(40);
    rd_chk(ra(5, 1), "R9");
    rd_chk(ra(5, 3), "R5");

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule